// File: doc/BRIEF.md
# Selectable-Period Input Debounce Filter

This block cleans up one already-synchronized input pin before the pin is sampled or checked for edges. While filtering is switched on, the filtered level moves to a new value only once the raw input has stayed at that value for a chosen number of millisecond ticks. A 3-bit exponent picks the length of that window: a code of n means 2^n ticks, which gives 1 ms up to 128 ms. When the enable bit is clear, the filter is skipped and the raw level passes straight through.

A neighbouring register stage delivers bits 8:5 of the pin's control word. The exponent is in bits 7:5 and the enable is in bit 8. The millisecond tick comes from a shared prescaler as a single-cycle strobe. Two events throw away any count in progress: the raw level going back to the filtered level, and a change of the exponent. The block uses a synchronous reset. During reset it loads the live raw level, so leaving reset never produces a false edge.

Top module: `debounce_filter`

## Requirements
- R1: Bits 7:5 of the control word hold the exponent code. Code n sets a window of 2^n ticks, so code 0 needs a single tick and code 7 needs 128 ticks.
- R2: When bit 8 of the control word is 0, `level_out` equals `raw_sync` in the same cycle, and the stability count stays at zero.
- R3: When bit 8 is 1, `level_out` takes the raw level on the clock edge at which the window-th tick is seen, provided the raw input has differed from the filtered level during all of those ticks.
- R4: While the filter is enabled, `level_out` changes at no other edge than the one described in R3.
- R5: If the raw input returns to the filtered level before the window completes, the count is cleared, and a further full window of ticks is then needed.
- R6: An edge at which the exponent code differs from its value on the previous edge clears the count, even if a tick is present. The new window is then counted from zero.
- R7: While `rst_n` is low at a clock edge, the filtered level loads `raw_sync` and the count is cleared.
- R8: While the filter is bypassed, the filtered level follows the raw input. Enabling the filter therefore never releases a stale level.
- R9: Clock cycles without `tick_ms` never advance the count, however long the raw input differs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| raw_sync | input | 1 | Raw pin level, already synchronized to clk |
| ctl_bits | input | 4 | Control word bits 8:5: [8] enable, [7:5] exponent code |
| level_out | output | 1 | Filtered (or bypassed) pin level |

## Verification
The assertions assume three things about the inputs. `raw_sync` and `ctl_bits` are stable around each clock edge. `tick_ms` is a level that the design samples on each edge. The exponent never moves outside its 3-bit field. The bench keeps to these conditions by driving every input only just after the falling edge and by building the control bits from a 3-bit code and one enable bit. The random phase holds the raw level steady for long stretches so that windows up to 128 ticks complete, alternates these stretches with noisy bursts that restart counts, and now and then changes the code or the enable during a count.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;

  typedef enum logic {
    DBF_BYPASS = 1'b0,
    DBF_ACTIVE = 1'b1
  } dbf_mode_e;

  // Window length in ticks for an exponent code: 2^code.
  function automatic int unsigned dbf_window_ticks(input int unsigned code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/dbf_cfg_decode.sv
`timescale 1ns/1ps
module dbf_cfg_decode #(
  parameter int CODE_LSB = 5,
  parameter int CODE_W   = 3,
  parameter int CNT_W    = 1 << CODE_W
) (
  input  logic [CODE_LSB+CODE_W:CODE_LSB] ctl_bits,
  output dbf_pkg::dbf_mode_e              mode,
  output logic [CODE_W-1:0]               code,
  output logic [CNT_W-1:0]                window
);
  localparam int EN_POS = CODE_LSB + CODE_W;

  always_comb begin
    code   = ctl_bits[EN_POS-1:CODE_LSB];
    mode   = ctl_bits[EN_POS] ? dbf_pkg::DBF_ACTIVE : dbf_pkg::DBF_BYPASS;
    window = CNT_W'(dbf_pkg::dbf_window_ticks(int'(code)));
  end

  // The window for any code is a single power of two.
  always_comb begin
    p_window_onehot_r1: assert ($onehot0(window) && window != '0)
      else $error("window not a power of two");
  end
endmodule

// File: rtl/dbf_stab_counter.sv
`timescale 1ns/1ps
module dbf_stab_counter #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              differ,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  window,
  output logic [CNT_W-1:0]  cnt,
  output logic              code_chg,
  output logic              restart,
  output logic              expire
);
  logic [CODE_W-1:0] code_q;
  logic              last_tick;

  assign code_chg  = active && (code != code_q);
  assign restart   = !active || !differ || code_chg;
  assign last_tick = (cnt == window - CNT_W'(1));
  assign expire    = !restart && tick && last_tick;

  always_ff @(posedge clk) begin
    code_q <= code;
    if (!rst_n || restart || expire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_expire_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !code_chg) |-> (cnt < window));
  p_bypass_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
  p_match_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !differ) |=> (cnt == '0));
  p_code_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> (cnt == '0));
  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/debounce_filter.sv
`timescale 1ns/1ps
module debounce_filter #(
  parameter int CODE_LSB = 5,
  parameter int CODE_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick_ms,
  input  logic                            raw_sync,
  input  logic [CODE_LSB+CODE_W:CODE_LSB] ctl_bits,
  output logic                            level_out
);
  localparam int CNT_W = 1 << CODE_W;

  dbf_pkg::dbf_mode_e mode;
  logic [CODE_W-1:0]  code;
  logic [CNT_W-1:0]   window;
  logic [CNT_W-1:0]   cnt;
  logic               active, differ, code_chg, restart, expire;
  logic               filt_q;

  dbf_cfg_decode #(.CODE_LSB(CODE_LSB), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_cfg (
    .ctl_bits (ctl_bits),
    .mode     (mode),
    .code     (code),
    .window   (window)
  );

  assign active = (mode == dbf_pkg::DBF_ACTIVE);
  assign differ = (raw_sync != filt_q);

  dbf_stab_counter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .differ   (differ),
    .tick     (tick_ms),
    .code     (code),
    .window   (window),
    .cnt      (cnt),
    .code_chg (code_chg),
    .restart  (restart),
    .expire   (expire)
  );

  // Filtered level: tracks raw in reset and bypass, flips on window expiry.
  always_ff @(posedge clk) begin
    if (!rst_n || !active || expire) begin
      filt_q <= raw_sync;
    end
  end

  assign level_out = active ? filt_q : raw_sync;

  p_hold_between_expiries_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !expire) |=> $stable(filt_q));
  p_expiry_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (filt_q != $past(filt_q)));
  p_expiry_only_when_differ_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> differ);
endmodule

// File: tb/debounce_filter_bench.sv
`timescale 1ns/1ps
module debounce_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       raw = 1'b0;
  logic [8:5] ctl = 4'h0;
  logic       level_out;

  int n_chk = 0;
  int n_fail = 0;
  bit m_f = 1'b0;
  int m_c = 0;
  int m_code = 0;

  always #2.5 clk = ~clk;

  debounce_filter u_debounce_filter (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick), .raw_sync(raw),
    .ctl_bits(ctl), .level_out(level_out)
  );

  function automatic int ref_window(int code);
    int p = 1;
    for (int i = 0; i < code; i++) p = p * 2;
    return p;
  endfunction

  function automatic logic [8:5] mk(bit en, int code);
    return {en, 3'(code)};
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(bit r, bit t, logic [8:5] c);
    raw = r; tick = t; ctl = c;
  endtask

  // One clock: update the reference at the rising edge, compare at the falling edge.
  task automatic cyc();
    int code;
    @(posedge clk);
    code = int'(ctl[7:5]);
    if (!rst_n || !ctl[8]) begin
      m_f = raw; m_c = 0;
    end else if (raw == m_f || code != m_code) begin
      m_c = 0;
    end else if (tick) begin
      if (m_c + 1 == ref_window(code)) begin m_f = raw; m_c = 0; end
      else m_c++;
    end
    m_code = code;
    @(negedge clk);
    chk("R4 reference", level_out, ctl[8] ? m_f : raw);
  endtask

  task automatic settle(bit lvl, int code);
    drive(lvl, 1'b1, mk(1'b1, code));
    repeat (ref_window(code) + 2) cyc();
    chk("R3 settle", level_out, lvl);
  endtask

  initial begin
    #600us;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit cur_raw, cur_en, noisy;
    int cur_code;
    void'($urandom(32'd4417));
    @(negedge clk);
    // R7: reset loads the raw level
    drive(1'b1, 1'b1, mk(1'b1, 1));
    repeat (3) cyc();
    chk("R7 in reset", level_out, 1'b1);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, mk(1'b1, 1));
    cyc();
    chk("R7 count zero after reset (1 of 2 ticks)", level_out, 1'b1);
    cyc();
    chk("R7 flips after 2 ticks", level_out, 1'b0);

    // R1: code 0 -> single tick
    settle(1'b0, 0);
    drive(1'b1, 1'b1, mk(1'b1, 0));
    cyc();
    chk("R1 code 0 one tick", level_out, 1'b1);

    // R1/R3: code 7 -> 128 ticks
    settle(1'b0, 7);
    drive(1'b1, 1'b1, mk(1'b1, 7));
    repeat (127) cyc();
    chk("R3 code 7 at 127 ticks", level_out, 1'b0);
    cyc();
    chk("R3 code 7 at 128 ticks", level_out, 1'b1);

    // R5: glitch back restarts the window
    settle(1'b0, 2);
    drive(1'b1, 1'b1, mk(1'b1, 2));
    repeat (3) cyc();
    drive(1'b0, 1'b1, mk(1'b1, 2));
    cyc();
    drive(1'b1, 1'b1, mk(1'b1, 2));
    repeat (3) cyc();
    chk("R5 restarted, 3 of 4", level_out, 1'b0);
    cyc();
    chk("R5 full window", level_out, 1'b1);

    // R6: code change mid-count restarts
    settle(1'b0, 3);
    drive(1'b1, 1'b1, mk(1'b1, 3));
    repeat (5) cyc();
    drive(1'b1, 1'b1, mk(1'b1, 2));
    cyc();
    repeat (3) cyc();
    chk("R6 restarted, 3 of 4", level_out, 1'b0);
    cyc();
    chk("R6 new window done", level_out, 1'b1);

    // R9: no tick, no progress
    settle(1'b0, 0);
    drive(1'b1, 1'b0, mk(1'b1, 0));
    repeat (50) cyc();
    chk("R9 no ticks", level_out, 1'b0);
    drive(1'b1, 1'b1, mk(1'b1, 0));
    cyc();
    chk("R9 first tick", level_out, 1'b1);

    // R2: bypass follows raw in the same cycle
    drive(1'b0, 1'b1, mk(1'b0, 7));
    #1 chk("R2 bypass low", level_out, 1'b0);
    cyc();
    drive(1'b1, 1'b0, mk(1'b0, 7));
    #1 chk("R2 bypass high", level_out, 1'b1);
    repeat (3) cyc();

    // R8: enabling after bypass keeps the current level
    drive(1'b1, 1'b1, mk(1'b1, 7));
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk("R8 no stale level", level_out, 1'b1);
    end

    // Random phase, compared against the reference every cycle
    cur_raw = 1'b1; cur_en = 1'b1; cur_code = 7; noisy = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(499) == 0) noisy = !noisy;
      if ($urandom_range(noisy ? 3 : 299) == 0) cur_raw = !cur_raw;
      if ($urandom_range(999) == 0) cur_code = $urandom_range(7);
      if ($urandom_range(1999) == 0) cur_en = !cur_en;
      drive(cur_raw, 1'($urandom_range(1)), mk(cur_en, cur_code));
      cyc();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule